// File: doc/BRIEF.md
# Asynchronous Parallel ROM Read Controller

This block lets a clocked host read an external asynchronous parallel ROM that can be used either 16 bits wide (word mode) or 8 bits wide (byte mode). The host raises a request with a 24-bit byte address and a width select. The controller then runs one read cycle on the ROM pins and returns the data with a one-cycle acknowledge. In word mode the returned value is the full 16-bit word. In byte mode it is the selected byte, zero-extended.

The ROM's most significant data pin has two roles. In word mode the ROM drives it as data bit 15, so the controller leaves it undriven. In byte mode the ROM takes it as the lowest address input, so the controller drives it with bit 0 of the host address.

The ROM's timing limits are met by wait-state counts given as parameters. Each count is the required time divided by the clock period, rounded up. One count covers access from address and chip enable, one covers access from output enable, and one covers the time the outputs need to float. Each read goes through the same sequence of states: idle, setup, access wait, capture, recover.

Top module: `arom_rd`

## Requirements
- R1: While reset is asserted, and after reset until the first accepted request: `rom_ce_n` and `rom_oe_n` are 1, `ack` is 0 and `rom_top_oe` is 0.
- R2: `rom_ce_n` is 1 whenever no read cycle is running. In the cycle after `ack`, both `rom_ce_n` and `rom_oe_n` are 1. `rom_ce_n` then stays 1 for at least FLT_CYC+1 cycles before it falls again.
- R3: `rom_oe_n` is 0 only while `rom_ce_n` is 0. `ack` rises exactly W+1 cycles after `rom_ce_n` falls, where W = max(ACC_CYC-1, OE_CYC).
- R4: Word mode (`byte_mode`=0): `rom_word`=1, `rom_a`=`addr[23:1]`, `rom_top_oe`=0, and `rdata`={`rom_top_i`, `rom_d[14:0]`}. `addr[0]` has no effect.
- R5: Byte mode (`byte_mode`=1): `rom_word`=0, `rom_top_oe`=1, `rom_top_o`=`addr[0]`, `rom_a`=`addr[23:1]`, and `rdata`={8'h00, `rom_d[7:0]`}. `rom_d[14:8]` and `rom_top_i` have no effect.
- R6: `rom_a`, `rom_word` and `rom_top_o` do not change while `rom_ce_n` is 0.
- R7: `ack` is a single-cycle pulse. `rdata` changes only in a cycle where `ack` is 1, and it holds its value until the next capture.
- R8: A request is taken only in the idle state. Address and width are latched when it is taken, and input changes during a running cycle have no effect on that cycle. A request held high past `ack` starts the next cycle once recovery is over.
- R9: Data is captured no earlier than ACC_CYC cycles after the address and chip enable are applied, and no earlier than OE_CYC cycles after `rom_oe_n` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Host read request, held until `ack` |
| byte_mode | input | 1 | 1 = byte read, 0 = word read |
| addr | input | AW+1 | Host byte address |
| ack | output | 1 | One-cycle read completion pulse |
| rdata | output | 16 | Returned data (byte zero-extended) |
| rom_ce_n | output | 1 | ROM chip enable, active low |
| rom_oe_n | output | 1 | ROM output enable, active low |
| rom_word | output | 1 | ROM width select, 1 = word mode |
| rom_a | output | AW | ROM word address |
| rom_d | input | 15 | ROM data lines 0 to 14 |
| rom_top_i | input | 1 | Dual-role pin, input side (data bit 15) |
| rom_top_o | output | 1 | Dual-role pin, output side (byte address LSB) |
| rom_top_oe | output | 1 | Dual-role pin drive enable |

## Verification
With the default counts (ACC_CYC=15, OE_CYC=7, FLT_CYC=3), `ack` is due exactly 15 cycles after chip enable falls, and `rdata` is valid in that same cycle. Chip enable must then stay high for at least 4 cycles. The bench ROM model is cycle-aware: it returns a junk pattern unless the access and output-enable times have elapsed by the next rising edge, so a capture made one cycle early returns wrong data. The monitor samples on falling edges. It counts falling edges from the chip-enable fall to the acknowledge, and pops the scoreboard entry queued by the driver in the cycle `ack` is seen.

// File: rtl/arom_rd.sv
`timescale 1ns/1ps
module arom_rd #(
  parameter int AW      = 23,
  parameter int ACC_CYC = 15,
  parameter int OE_CYC  = 7,
  parameter int FLT_CYC = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          byte_mode,
  input  logic [AW:0]   addr,
  output logic          ack,
  output logic [15:0]   rdata,
  output logic          rom_ce_n,
  output logic          rom_oe_n,
  output logic          rom_word,
  output logic [AW-1:0] rom_a,
  input  logic [14:0]   rom_d,
  input  logic          rom_top_i,
  output logic          rom_top_o,
  output logic          rom_top_oe
);
  localparam int WAIT_RAW = (ACC_CYC - 1 > OE_CYC) ? ACC_CYC - 1 : OE_CYC;
  localparam int WAIT_N   = (WAIT_RAW < 1) ? 1 : WAIT_RAW;
  localparam int FLT_N    = (FLT_CYC < 1) ? 1 : FLT_CYC;
  localparam int CMAX     = (WAIT_N > FLT_N) ? WAIT_N : FLT_N;
  localparam int CW       = $clog2(CMAX + 1);

  typedef enum logic [2:0] {IDLE, SETUP, WAIT_ACC, CAPTURE, RECOVER} st_t;
  st_t st;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= IDLE;
      cnt       <= '0;
      rom_a     <= '0;
      rom_word  <= 1'b1;
      rom_top_o <= 1'b0;
      rdata     <= '0;
    end else begin
      case (st)
        IDLE: if (req) begin
          rom_a     <= addr[AW:1];
          rom_word  <= ~byte_mode;
          rom_top_o <= addr[0];
          st        <= SETUP;
        end
        SETUP: begin
          cnt <= CW'(WAIT_N - 1);
          st  <= WAIT_ACC;
        end
        WAIT_ACC: if (cnt == '0) begin
          rdata <= rom_word ? {rom_top_i, rom_d} : {8'h00, rom_d[7:0]};
          st    <= CAPTURE;
        end else begin
          cnt <= cnt - 1'b1;
        end
        CAPTURE: begin
          cnt <= CW'(FLT_N - 1);
          st  <= RECOVER;
        end
        RECOVER: if (cnt == '0) st <= IDLE;
                 else cnt <= cnt - 1'b1;
        default: st <= IDLE;
      endcase
    end
  end

  assign ack        = (st == CAPTURE);
  assign rom_ce_n   = (st == IDLE) || (st == RECOVER);
  assign rom_oe_n   = !((st == WAIT_ACC) || (st == CAPTURE));
  assign rom_top_oe = !rom_word;

  logic [15:0] lo_age, oe_age, hi_age;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_age <= '0;
      oe_age <= '0;
      hi_age <= '1;
    end else begin
      lo_age <= rom_ce_n ? '0 : ((lo_age == '1) ? lo_age : lo_age + 1'b1);
      oe_age <= rom_oe_n ? '0 : ((oe_age == '1) ? oe_age : oe_age + 1'b1);
      hi_age <= !rom_ce_n ? '0 : ((hi_age == '1) ? hi_age : hi_age + 1'b1);
    end
  end

  assert_oe_under_ce_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !rom_oe_n |-> !rom_ce_n);
  assert_release_after_ack_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> (rom_ce_n && rom_oe_n));
  assert_float_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rom_ce_n) |-> (hi_age >= 16'(FLT_CYC + 1)));
  assert_access_time_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> (lo_age >= 16'(ACC_CYC) && oe_age >= 16'(OE_CYC)));
  assert_addr_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!rom_ce_n && $past(!rom_ce_n)) |-> ($stable(rom_a) && $stable(rom_word) && $stable(rom_top_o)));
  assert_ack_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack);
  assert_rdata_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rdata) |-> ack);
endmodule

// File: tb/arom_rd_bench.sv
`timescale 1ns/1ps
module arom_rd_bench;
  localparam int AW = 23, ACC_CYC = 15, OE_CYC = 7, FLT_CYC = 3;
  localparam int ACC_NS = 120, OE_NS = 50, HALF = 4;
  localparam int WN = (ACC_CYC - 1 > OE_CYC) ? ACC_CYC - 1 : OE_CYC;

  logic clk = 0, rst_n = 0, req = 0, byte_mode = 0;
  logic [AW:0] addr = '0;
  logic ack, rom_ce_n, rom_oe_n, rom_word, rom_top_o, rom_top_oe, rom_top_i;
  logic [15:0] rdata;
  logic [AW-1:0] rom_a;
  logic [14:0] rom_d;
  logic [15:0] mem_o = 16'hDEAD;

  always #4 clk = ~clk;

  arom_rd #(.AW(AW), .ACC_CYC(ACC_CYC), .OE_CYC(OE_CYC), .FLT_CYC(FLT_CYC)) u_arom_rd (
    .clk(clk), .rst_n(rst_n), .req(req), .byte_mode(byte_mode), .addr(addr),
    .ack(ack), .rdata(rdata), .rom_ce_n(rom_ce_n), .rom_oe_n(rom_oe_n),
    .rom_word(rom_word), .rom_a(rom_a), .rom_d(rom_d), .rom_top_i(rom_top_i),
    .rom_top_o(rom_top_o), .rom_top_oe(rom_top_oe));

  int checks = 0, errors = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  function automatic logic [15:0] romw(input logic [AW-1:0] a);
    return a[15:0] ^ {a[22:16], 9'h000} ^ 16'h3C5A;
  endfunction

  // ROM model: valid data only when timing limits are met by the next rising edge
  time t_addr = 0, t_ce = 0, t_oe = 0;
  always @(rom_a or rom_word or rom_top_o) t_addr = $time;
  always @(negedge rom_ce_n) t_ce = $time;
  always @(negedge rom_oe_n) t_oe = $time;
  always @(negedge clk) begin
    time tn;
    logic [15:0] w;
    tn = $time + HALF;
    if (!rom_ce_n && !rom_oe_n && tn - t_addr >= ACC_NS && tn - t_ce >= ACC_NS && tn - t_oe >= OE_NS) begin
      w = romw(rom_a);
      if (rom_word) mem_o = w;
      else mem_o = {8'hD7, rom_top_o ? w[15:8] : w[7:0]};
    end else begin
      mem_o = 16'hDEAD;
    end
  end
  assign rom_d     = mem_o[14:0];
  assign rom_top_i = mem_o[15];

  // scoreboard entry: {byte, lsb, word addr, data}
  logic [40:0] exp_q[$];

  function automatic logic [15:0] expect_data(input bit bm, input logic [AW:0] a);
    logic [15:0] w;
    w = romw(a[AW:1]);
    if (!bm) return w;
    return {8'h00, a[0] ? w[15:8] : w[7:0]};
  endfunction

  task automatic push(input bit bm, input logic [AW:0] a);
    exp_q.push_back({bm, a[0], a[AW:1], expect_data(bm, a)});
  endtask

  task automatic rd(input bit bm, input logic [AW:0] a);
    push(bm, a);
    @(negedge clk);
    req = 1; byte_mode = bm; addr = a;
    do @(negedge clk); while (!ack);
    req = 0;
  endtask

  // monitor
  int cyc = 0, fall_cyc = 0, hi_run = 1000;
  bit prev_ce_n = 1, prev_ack = 0;
  logic [AW-1:0] a_at;
  logic w_at, p_at;
  bit moved = 0;
  always @(negedge clk) begin
    logic [40:0] e;
    cyc++;
    if (rst_n) begin
      if (!rom_ce_n && prev_ce_n) begin
        chk(hi_run >= FLT_CYC + 1, "R2 chip enable high gap", hi_run, FLT_CYC + 1);
        fall_cyc = cyc; a_at = rom_a; w_at = rom_word; p_at = rom_top_o; moved = 0;
      end
      if (!rom_ce_n && (rom_a != a_at || rom_word != w_at || rom_top_o != p_at)) moved = 1;
      if (!rom_oe_n) chk(!rom_ce_n, "R3 output enable without chip enable", rom_ce_n, 0);
      if (prev_ack) chk(rom_ce_n && rom_oe_n, "R2 enables released after ack", {rom_ce_n, rom_oe_n}, 2'b11);
      if (ack) begin
        if (exp_q.size() == 0) chk(0, "R8 unexpected ack", 1, 0);
        else begin
          e = exp_q.pop_front();
          chk(cyc - fall_cyc == WN + 1, "R3/R9 ack latency", cyc - fall_cyc, WN + 1);
          chk(!moved, "R6 address stable during cycle", moved, 0);
          chk(rom_a == e[38:16], "R8 latched word address", rom_a, e[38:16]);
          if (e[40]) begin
            chk(rdata == e[15:0], "R5 byte data", rdata, e[15:0]);
            chk(!rom_word && rom_top_oe && rom_top_o == e[39], "R5 byte pins",
                {rom_word, rom_top_oe, rom_top_o}, {2'b01, e[39]});
          end else begin
            chk(rdata == e[15:0], "R4 word data", rdata, e[15:0]);
            chk(rom_word && !rom_top_oe, "R4 word pins", {rom_word, rom_top_oe}, 2'b10);
          end
        end
      end
      hi_run = rom_ce_n ? hi_run + 1 : 0;
      prev_ce_n = rom_ce_n;
      prev_ack = ack;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    summary();
  end

  initial begin
    logic [15:0] keep;
    repeat (3) @(negedge clk);
    chk(rom_ce_n && rom_oe_n && !ack && !rom_top_oe, "R1 in reset",
        {rom_ce_n, rom_oe_n, ack, rom_top_oe}, 4'b1100);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk(rom_ce_n && rom_oe_n && !ack && !rom_top_oe, "R1 after reset idle",
        {rom_ce_n, rom_oe_n, ack, rom_top_oe}, 4'b1100);

    rd(0, 24'h000000);                   // R4
    rd(0, 24'h123456);
    rd(0, 24'h123457);                   // R4 addr[0] ignored
    rd(0, 24'hFFFFFE);
    rd(1, 24'h000000);                   // R5 even byte
    rd(1, 24'h000001);                   // R5 odd byte
    rd(1, 24'hABCDEF);
    rd(1, 24'hFFFFFF);
    rd(0, 24'h800000);

    // R7: rdata holds after ack
    keep = rdata;
    repeat (6) @(negedge clk);
    chk(rdata == keep, "R7 rdata held", rdata, keep);
    chk(!ack, "R7 ack single pulse", ack, 0);

    // R8: inputs changed mid-cycle have no effect
    push(1, 24'h345679);
    @(negedge clk);
    req = 1; byte_mode = 1; addr = 24'h345679;
    repeat (4) @(negedge clk);
    byte_mode = 0; addr = 24'h0F0F0E;
    do @(negedge clk); while (!ack);
    req = 0;

    // R8: request held across ack starts the next read after recovery
    push(0, 24'h222222);
    push(1, 24'h3AAAAA);
    @(negedge clk);
    req = 1; byte_mode = 0; addr = 24'h222222;
    do @(negedge clk); while (!ack);
    byte_mode = 1; addr = 24'h3AAAAA;
    @(negedge clk);
    do @(negedge clk); while (!ack);
    req = 0;

    repeat (10) @(negedge clk);
    chk(exp_q.size() == 0, "R8 all requests answered", exp_q.size(), 0);
    chk(rom_ce_n && rom_oe_n, "R2 idle enables high", {rom_ce_n, rom_oe_n}, 2'b11);
    summary();
  end
endmodule